// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the instruction fetch address of a small 8-bit core. In normal flow the address steps forward by one slot every cycle. Decode logic outside the block reports two events. The first is an unconditional jump, which carries an 11-bit immediate. The second is a request to skip the next instruction. A jump cannot reach the whole 15-bit space from its immediate alone. The upper four address bits come from a separate 7-bit page latch, which software loads through its own write port before it branches.

A jump or a taken skip discards the instruction that is already in flight. The block marks the slot that follows as a no-operation so that downstream logic can suppress any register or flag update in it. Both events therefore cost two instruction cycles. The block changes no status flags. Instruction memory, decode and call or return stacks sit outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held (rst_n low), and in the first cycle after it, fetch_addr_o is 0 and nop_slot_o is 0. The page latch resets to 0.
- R2: When no jump is taken, fetch_addr_o advances by exactly 1 each cycle. It wraps from 0x7FFF to 0x0000.
- R3: A jump accepted in a cycle makes the next fetch address equal to the concatenation {page[6:3], jump_imm_i[10:0]}. Page bits 6..3 become address bits 14..11, and the immediate becomes address bits 10..0.
- R4: Page latch bits 2..0 have no effect on any jump target.
- R5: An accepted jump sets nop_slot_o high for exactly the following cycle. In the cycle after that, the address is target+1 and nop_slot_o is low, so the jump costs two cycles.
- R6: An accepted skip_i sets nop_slot_o high in the following cycle. The address keeps advancing by one, so the skipped instruction's slot is squashed.
- R7: In a cycle where nop_slot_o is high, jump_i and skip_i are ignored. The next address is the current address + 1, and nop_slot_o returns low.
- R8: A page write (page_we_i) takes effect from the next cycle. A jump in the same cycle as a page write uses the previous latch value.
- R9: When neither jump_i nor skip_i is accepted, the next slot executes normally: nop_slot_o stays low.
- R10: If jump_i and skip_i are both asserted in an accepted cycle, the jump takes priority and the target is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_i | input | 1 | Decoded unconditional jump in the current slot |
| jump_imm_i | input | 11 | Jump immediate, low address bits |
| skip_i | input | 1 | Skip request for the following instruction |
| page_we_i | input | 1 | Page latch write enable |
| page_wdata_i | input | 7 | Page latch write data |
| fetch_addr_o | output | 15 | Current fetch address |
| nop_slot_o | output | 1 | Current slot executes as a no-operation |

## Verification
The bound checker watches several relations on every cycle, using only the ports. The address must step by one whenever no jump is accepted. Every accepted jump or skip must raise the no-operation flag for exactly one slot. Requests that arrive during a flushed slot must change nothing, and the low 11 target bits must follow the immediate. The page-dependent upper bits cannot be checked that way, because the latch is internal. The ignored low page bits, the same-cycle write ordering and the wrap at the top of the address space appear only in the bench's directed scenarios.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    localparam int PC_WIDTH   = 15;
    localparam int IMM_WIDTH  = 11;
    localparam int PAGE_WIDTH = 7;
    localparam int PAGE_LSB   = 3;
endpackage

// File: rtl/pc_page_latch.sv
module pc_page_latch #(
    parameter int WIDTH = pc_seq_pkg::PAGE_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] page_o
);
    logic [WIDTH-1:0] page_d, page_q;

    always_comb begin
        page_d = page_q;
        if (we_i) page_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) page_q <= '0;
        else        page_q <= page_d;
    end

    assign page_o = page_q;
endmodule

// File: rtl/pc_target_build.sv
module pc_target_build #(
    parameter int PC_W   = pc_seq_pkg::PC_WIDTH,
    parameter int IMM_W  = pc_seq_pkg::IMM_WIDTH,
    parameter int PAGE_W = pc_seq_pkg::PAGE_WIDTH,
    parameter int P_LSB  = pc_seq_pkg::PAGE_LSB
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [PC_W-1:0]   target_o
);
    localparam int HI_W = PC_W - IMM_W;

    generate
        if (HI_W > 0) begin : g_paged
            assign target_o = {page_i[P_LSB +: HI_W], imm_i};
        end else begin : g_flat
            assign target_o = imm_i[PC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int PC_W   = pc_seq_pkg::PC_WIDTH,
    parameter int IMM_W  = pc_seq_pkg::IMM_WIDTH,
    parameter int PAGE_W = pc_seq_pkg::PAGE_WIDTH,
    parameter int P_LSB  = pc_seq_pkg::PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jump_i,
    input  logic [IMM_W-1:0]  jump_imm_i,
    input  logic              skip_i,
    input  logic              page_we_i,
    input  logic [PAGE_W-1:0] page_wdata_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              nop_slot_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            nop;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic [PAGE_W-1:0] page_q;
    logic [PC_W-1:0]   target;
    logic              accept;

    pc_page_latch #(.WIDTH(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (page_we_i),
        .wdata_i (page_wdata_i),
        .page_o  (page_q)
    );

    pc_target_build #(
        .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .P_LSB(P_LSB)
    ) u_target (
        .imm_i    (jump_imm_i),
        .page_i   (page_q),
        .target_o (target)
    );

    assign accept = !st_q.nop;

    always_comb begin
        st_d.pc  = st_q.pc + {{(PC_W-1){1'b0}}, 1'b1};
        st_d.nop = 1'b0;
        if (accept) begin
            if (jump_i) begin
                st_d.pc  = target;
                st_d.nop = 1'b1;
            end else if (skip_i) begin
                st_d.nop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr_o = st_q.pc;
    assign nop_slot_o   = st_q.nop;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W  = pc_seq_pkg::PC_WIDTH,
    parameter int IMM_W = pc_seq_pkg::IMM_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             jump_i,
    input logic [IMM_W-1:0] jump_imm_i,
    input logic             skip_i,
    input logic [PC_W-1:0]  fetch_addr_o,
    input logic             nop_slot_o
);
    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nop_slot_o || !jump_i) |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

    // R3
    jump_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot_o && jump_i) |=> fetch_addr_o[IMM_W-1:0] == $past(jump_imm_i));

    // R5
    jump_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot_o && jump_i) |=> nop_slot_o);

    // R6
    skip_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot_o && skip_i) |=> nop_slot_o);

    // R7
    single_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nop_slot_o |=> !nop_slot_o);

    // R9
    normal_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nop_slot_o && !jump_i && !skip_i) |=> !nop_slot_o);
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .IMM_W(IMM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .jump_i       (jump_i),
    .jump_imm_i   (jump_imm_i),
    .skip_i       (skip_i),
    .fetch_addr_o (fetch_addr_o),
    .nop_slot_o   (nop_slot_o)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        jump_i;
    logic [10:0] jump_imm_i;
    logic        skip_i;
    logic        page_we_i;
    logic [6:0]  page_wdata_i;
    logic [14:0] fetch_addr_o;
    logic        nop_slot_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .jump_i(jump_i), .jump_imm_i(jump_imm_i),
        .skip_i(skip_i), .page_we_i(page_we_i), .page_wdata_i(page_wdata_i),
        .fetch_addr_o(fetch_addr_o), .nop_slot_o(nop_slot_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        jump_i = 1'b0; skip_i = 1'b0; page_we_i = 1'b0;
    endtask

    task automatic write_page(input logic [6:0] v);
        page_we_i = 1'b1; page_wdata_i = v;
        step();
        page_we_i = 1'b0;
    endtask

    // jump and return the address reached in the flushed slot
    task automatic do_jump(input logic [10:0] imm, output logic [14:0] got, output logic nop);
        jump_i = 1'b1; jump_imm_i = imm;
        step();
        jump_i = 1'b0;
        got = fetch_addr_o; nop = nop_slot_o;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); jump_imm_i = '0; page_wdata_i = '0;
        repeat (3) step();
        check("R1 addr in reset", {1'b0, fetch_addr_o}, 16'h0);
        check("R1 nop in reset", {15'b0, nop_slot_o}, 16'h0);
        rst_n = 1'b1;
        #0;
        check("R1 first cycle", {nop_slot_o, fetch_addr_o}, 16'h0);
    endtask

    task automatic t_sequential();
        logic [14:0] a;
        a = fetch_addr_o;
        for (int i = 1; i <= 5; i++) begin
            step();
            check("R2 increment", {1'b0, fetch_addr_o}, {1'b0, a + 15'(i)});
            check("R9 no flush", {15'b0, nop_slot_o}, 16'h0);
        end
    endtask

    task automatic t_jump_page_zero();
        logic [14:0] g; logic n;
        do_jump(11'h5A3, g, n);
        check("R3 target page 0", {1'b0, g}, 16'h05A3);
        check("R5 flush slot", {15'b0, n}, 16'h1);
        step();
        check("R5 after flush", {nop_slot_o, fetch_addr_o}, {1'b0, 15'h05A4});
    endtask

    task automatic t_jump_paged();
        logic [14:0] g; logic n;
        write_page(7'b1010_000);
        do_jump(11'h123, g, n);
        check("R3 paged target", {1'b0, g}, {1'b0, 4'hA, 11'h123});
        step();
    endtask

    task automatic t_low_page_bits();
        logic [14:0] g; logic n;
        write_page(7'b0011_111);
        do_jump(11'h7F0, g, n);
        check("R4 low page bits ignored", {1'b0, g}, {1'b0, 4'h3, 11'h7F0});
        write_page(7'b0011_000);
        do_jump(11'h7F0, g, n);
        check("R4 low page bits cleared", {1'b0, g}, {1'b0, 4'h3, 11'h7F0});
        step();
    endtask

    task automatic t_skip();
        logic [14:0] a;
        a = fetch_addr_o;
        skip_i = 1'b1;
        step();
        skip_i = 1'b0;
        check("R6 skip flush", {nop_slot_o, fetch_addr_o}, {1'b1, a + 15'd1});
        step();
        check("R6 after skip", {nop_slot_o, fetch_addr_o}, {1'b0, a + 15'd2});
    endtask

    task automatic t_ignore_in_flush();
        logic [14:0] a;
        skip_i = 1'b1;
        step();
        a = fetch_addr_o;
        check("R7 enter flush", {15'b0, nop_slot_o}, 16'h1);
        jump_i = 1'b1; jump_imm_i = 11'h011; skip_i = 1'b1;
        step();
        idle();
        check("R7 requests ignored", {nop_slot_o, fetch_addr_o}, {1'b0, a + 15'd1});
        step();
        check("R7 still sequential", {nop_slot_o, fetch_addr_o}, {1'b0, a + 15'd2});
    endtask

    task automatic t_same_cycle_write();
        logic [14:0] g; logic n;
        write_page(7'b0101_000);
        page_we_i = 1'b1; page_wdata_i = 7'b1100_000;
        do_jump(11'h0AA, g, n);
        page_we_i = 1'b0;
        check("R8 old page used", {1'b0, g}, {1'b0, 4'h5, 11'h0AA});
        step();
        do_jump(11'h0AA, g, n);
        check("R8 new page later", {1'b0, g}, {1'b0, 4'hC, 11'h0AA});
        step();
    endtask

    task automatic t_priority();
        logic [14:0] g; logic n;
        write_page(7'b0000_000);
        skip_i = 1'b1;
        do_jump(11'h200, g, n);
        skip_i = 1'b0;
        check("R10 jump wins", {n, g}, {1'b1, 15'h0200});
        step();
    endtask

    task automatic t_wrap();
        logic [14:0] g; logic n;
        write_page(7'b1111_000);
        do_jump(11'h7FF, g, n);
        check("R2 top address", {1'b0, g}, 16'h7FFF);
        step();
        check("R2 wrap to zero", {nop_slot_o, fetch_addr_o}, 16'h0000);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sequential();
        t_jump_page_zero();
        t_jump_paged();
        t_low_page_bits();
        t_skip();
        t_ignore_in_flush();
        t_same_cycle_write();
        t_priority();
        t_wrap();
        t_sequential();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule